// File: doc/BRIEF.md
# Three-Wire Serial Memory Host Controller

This block sits on the host side of a three-wire serial memory link (select, clock, data toward the memory, data back from it). A client hands it one command at a time: a command code, a cell address and, for the storing commands, a data word. The controller then builds the serial instruction frame, clocks it out on a serial clock divided down from the system clock and, for a read, collects the returned word. After any command that changes the array, it re-selects the memory and watches the returned data line until the memory reports that its internal cycle is finished.

When the memory reports ready, the controller sends one extra clocked 1 bit before deselecting. This makes the memory stop driving its output, so the two data lines can be tied together into one. If the memory stays busy for too long, the controller gives up and flags a timeout. A parameter selects 16-bit word organisation (8 address bits) or 8-bit byte organisation (9 address bits). The serial clock half-period and the busy-wait limit are also parameters.

Top module: `mwire_host`

## Requirements
- R1: While reset is asserted and after it is released, `mw_cs`, `mw_sk`, `mw_di`, `rsp_done` and `rsp_timeout` are low and `req_ready` is high.
- R2: A frame goes out MSB first on `mw_di`. It is a 1 start bit, a 2-bit operation code, the address, and then the data word (for the two storing commands only). `mw_di` never changes while `mw_sk` is high.
- R3: The command codes on `req_cmd` are 0 read, 1 store, 2 clear, 3 enable-modify, 4 disable-modify, 5 clear-all and 6 store-all; code 7 acts as disable-modify. The operation codes sent are read 10, store 01 and clear 11. The other four commands send 00, followed by the two top address bits 11 (enable), 00 (disable), 10 (clear-all) or 01 (store-all), with every lower address bit sent as 0.
- R4: With 16-bit words the address field has 8 bits, so an enable-modify frame has 11 serial clock rising edges. With 8-bit bytes it has 9 bits.
- R5: After the address of a read, the controller gives DW+1 more serial clock rising edges. It samples `mw_do` just before each rising edge and drops the first sample, which is the leading dummy 0. The word appears MSB-aligned on `rsp_rdata` when `rsp_done` pulses, so a read frame has 28 rising edges with 16-bit words.
- R6: After store, clear, clear-all and store-all, `mw_cs` is low for one bit period and is then raised with `mw_sk` idle. The controller waits while `mw_do` is low. Once `mw_do` is high, it sends one clocked dummy 1 and deselects. Enable-modify and disable-modify end without this wait.
- R7: If `mw_do` stays low for POLL_MAX system cycles of waiting, the controller deselects without the dummy bit and completes with `rsp_timeout` high. The flag is cleared when the next command is accepted.
- R8: One serial clock period is 2*HALF system cycles, with the clock high for HALF cycles. `mw_sk` is low whenever `mw_cs` is low.
- R9: Between any two selections, `mw_cs` stays low for at least one full serial bit period (2*HALF system cycles).
- R10: `req_start` is taken only while `req_ready` is high. `req_ready` is low from acceptance until the single-cycle `rsp_done` pulse, and it rises together with that pulse. A `req_start` seen while busy causes no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Command request strobe |
| req_cmd | input | 3 | Command code (see R3) |
| req_addr | input | AW | Cell address (8 for words, 9 for bytes) |
| req_wdata | input | DW | Data for store and store-all |
| req_ready | output | 1 | Idle, a new command may be given |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Word collected by the last read |
| rsp_timeout | output | 1 | Busy wait gave up on the last command |
| mw_cs | output | 1 | Memory select |
| mw_sk | output | 1 | Divided serial clock |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data and ready status from the memory |

## Verification
A wrong bit counter or shift register shows on `mw_di` within one serial bit period: a frame with the wrong number of rising edges, or a wrong operation or address decoded at the memory. A slip in read sampling shows as a word shifted by one place as soon as `rsp_done` pulses. A wrong busy-wait state shows at the end of that command: either a missing dummy release bit, or `rsp_timeout` raised while the memory is ready (or missing while it is busy). A full sweep over all word addresses, writing and reading back an address-derived pattern, exposes any address or data bit that is dropped or swapped.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_READ    = 3'd0,
    CMD_STORE   = 3'd1,
    CMD_CLEAR   = 3'd2,
    CMD_WREN    = 3'd3,
    CMD_WRDIS   = 3'd4,
    CMD_CLRALL  = 3'd5,
    CMD_FILLALL = 3'd6
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_READ,
    ST_GAP,
    ST_POLL,
    ST_REL,
    ST_END
  } mw_state_e;

endpackage

// File: rtl/mw_bit_timer.sv
// Serial bit period generator: low half, then high half, each HALF cycles.
module mw_bit_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk_phase,
  output logic pre_rise,
  output logic bit_end
);
  localparam int PER = 2 * HALF;
  localparam int TW  = (PER > 2) ? $clog2(PER) : 1;

  logic [TW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    bit_end  = run && (tcnt_q == TW'(PER - 1));
    pre_rise = run && (tcnt_q == TW'(HALF - 1));
    sk_phase = run && (tcnt_q >= TW'(HALF));
    if (!run || bit_end) tcnt_d = '0;
    else                 tcnt_d = tcnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  AST_SK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_phase) |-> $past(pre_rise)); // R8

endmodule

// File: rtl/mw_frame.sv
// Builds the left-aligned instruction frame and its length.
module mw_frame
  import mw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int FW = 3 + AW + DW,
  parameter int CW = 5
) (
  input  mw_cmd_e         cmd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [FW-1:0]   frame,
  output logic [CW-1:0]   nbits,
  output logic            is_read,
  output logic            is_mod
);
  logic [1:0]    op;
  logic [AW-1:0] af;
  logic [DW-1:0] dat;

  always_comb begin
    op      = 2'b00;
    af      = addr;
    dat     = '0;
    is_read = 1'b0;
    is_mod  = 1'b0;
    case (cmd)
      CMD_READ:    begin op = 2'b10; is_read = 1'b1; end
      CMD_STORE:   begin op = 2'b01; dat = wdata; is_mod = 1'b1; end
      CMD_CLEAR:   begin op = 2'b11; is_mod = 1'b1; end
      CMD_WREN:    af = {2'b11, {(AW-2){1'b0}}};
      CMD_CLRALL:  begin af = {2'b10, {(AW-2){1'b0}}}; is_mod = 1'b1; end
      CMD_FILLALL: begin af = {2'b01, {(AW-2){1'b0}}}; dat = wdata; is_mod = 1'b1; end
      default:     af = '0;
    endcase
    frame = {1'b1, op, af, dat};
    if (cmd == CMD_STORE || cmd == CMD_FILLALL) nbits = CW'(FW);
    else                                        nbits = CW'(FW - DW);
  end

endmodule

// File: rtl/mwire_host.sv
module mwire_host
  import mw_pkg::*;
#(
  parameter bit WORD16   = 1'b1,
  parameter int HALF     = 2,
  parameter int POLL_MAX = 4096,
  localparam int DW      = WORD16 ? 16 : 8,
  localparam int AW      = WORD16 ? 8 : 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [2:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic          mw_cs,
  output logic          mw_sk,
  output logic          mw_di,
  input  logic          mw_do
);
  localparam int FW = 3 + AW + DW;
  localparam int CW = $clog2(FW + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int RW = DW + 1;

  mw_state_e     state_q, state_d;
  logic [FW-1:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] poll_q, poll_d;
  logic [RW-1:0] rd_q, rd_d;
  logic          rdk_q, rdk_d, mod_q, mod_d, to_q, to_d, done_q, done_d;

  logic [FW-1:0] fr_bits;
  logic [CW-1:0] fr_len;
  logic          fr_rd, fr_mod;
  logic          run, sk_phase, pre_rise, bit_end;

  mw_frame #(.AW(AW), .DW(DW), .FW(FW), .CW(CW)) u_frame (
    .cmd     (mw_cmd_e'(req_cmd)),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .frame   (fr_bits),
    .nbits   (fr_len),
    .is_read (fr_rd),
    .is_mod  (fr_mod)
  );

  assign run = (state_q != ST_IDLE) && (state_q != ST_POLL);

  mw_bit_timer #(.HALF(HALF)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sk_phase (sk_phase),
    .pre_rise (pre_rise),
    .bit_end  (bit_end)
  );

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    poll_d  = poll_q;
    rd_d    = rd_q;
    rdk_d   = rdk_q;
    mod_d   = mod_q;
    to_d    = to_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_start) begin
        state_d = ST_SEND;
        sr_d    = fr_bits;
        cnt_d   = fr_len - CW'(1);
        rdk_d   = fr_rd;
        mod_d   = fr_mod;
        to_d    = 1'b0;
      end
      ST_SEND: if (bit_end) begin
        sr_d = {sr_q[FW-2:0], 1'b0};
        if (cnt_q == '0) begin
          if (rdk_q) begin
            state_d = ST_READ;
            cnt_d   = CW'(DW);
          end else if (mod_q) begin
            state_d = ST_GAP;
          end else begin
            state_d = ST_END;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_READ: begin
        if (pre_rise) rd_d = {rd_q[DW-1:0], mw_do};
        if (bit_end) begin
          if (cnt_q == '0) state_d = ST_END;
          else             cnt_d   = cnt_q - CW'(1);
        end
      end
      ST_GAP: if (bit_end) begin
        state_d = ST_POLL;
        poll_d  = '0;
      end
      ST_POLL: begin
        if (mw_do) begin
          state_d = ST_REL;
        end else if (poll_q == PW'(POLL_MAX - 1)) begin
          state_d = ST_END;
          to_d    = 1'b1;
        end else begin
          poll_d = poll_q + PW'(1);
        end
      end
      ST_REL: if (bit_end) state_d = ST_END;
      ST_END: if (bit_end) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      cnt_q   <= '0;
      poll_q  <= '0;
      rd_q    <= '0;
      rdk_q   <= 1'b0;
      mod_q   <= 1'b0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      poll_q  <= poll_d;
      rd_q    <= rd_d;
      rdk_q   <= rdk_d;
      mod_q   <= mod_d;
      to_q    <= to_d;
      done_q  <= done_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_done    = done_q;
  assign rsp_timeout = to_q;
  assign rsp_rdata   = rd_q[DW-1:0];
  assign mw_cs       = (state_q == ST_SEND) || (state_q == ST_READ) ||
                       (state_q == ST_POLL) || (state_q == ST_REL);
  assign mw_sk       = sk_phase && ((state_q == ST_SEND) || (state_q == ST_READ) ||
                                    (state_q == ST_REL));
  assign mw_di       = (state_q == ST_SEND) ? sr_q[FW-1] : (state_q == ST_REL);

  AST_DI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di)); // R2
  AST_SK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_sk); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |=> !mw_cs); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_start) |=> !req_ready); // R10
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && mw_do) |=> (mw_cs && mw_di)); // R6
  AST_TIMEOUT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_timeout) |-> !mw_cs); // R7

endmodule

// File: tb/sim_mwire_host.sv
`timescale 1ns/1ps
module sim_mwire_host;
  localparam int HALF = 2;
  localparam int PMAX = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start;
  logic [2:0]  req_cmd;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_done, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic        mw_cs, mw_sk, mw_di;
  logic        mdo;

  always #2.5 clk = ~clk;

  mwire_host #(.WORD16(1'b1), .HALF(HALF), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mdo)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural serial memory ----------------
  logic [15:0] mem [256];
  int   ph, n, busy, busy_len, frames, rel_cnt, frame_err, sk_err;
  int   sk_hi_run, sk_per, cslow_run, min_cslow, nb, last_nb;
  logic [1:0]  mop;
  logic [7:0]  mad;
  logic [15:0] mdat, rword;
  logic wen, poll_ses, poll_pending, cs_p, sk_p;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    ph = 0; n = 0; busy = 0; busy_len = 20; frames = 0; rel_cnt = 0;
    frame_err = 0; sk_err = 0; sk_hi_run = 0; sk_per = 0; cslow_run = 0;
    min_cslow = 1000000; nb = 0; last_nb = 0; mop = 0; mad = 0; mdat = 0;
    rword = 0; wen = 0; poll_ses = 0; poll_pending = 0; cs_p = 0; sk_p = 0;
    mdo = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy > 0) busy--;
      // serial clock shape
      if (mw_sk) sk_hi_run++;
      else begin
        if (sk_p && sk_hi_run != HALF) sk_err++;
        sk_hi_run = 0;
      end
      if (mw_sk && !sk_p) begin
        if (sk_per != 0 && sk_per != 2*HALF) sk_err++;
        sk_per = 1;
      end else if (sk_per != 0) sk_per++;
      if (mw_sk && !mw_cs) sk_err++;
      // select edges
      if (!mw_cs) cslow_run++;
      if (mw_cs && !cs_p) begin
        if (cslow_run < min_cslow) min_cslow = cslow_run;
        cslow_run = 0; nb = 0; ph = 0; poll_ses = poll_pending;
      end
      if (!mw_cs && cs_p) begin
        if (!poll_ses) begin
          frames++; last_nb = nb;
          if (ph == 3) begin
            case (mop)
              2'b01: begin if (wen) begin mem[mad] = mdat; busy = busy_len; end poll_pending = 1; end
              2'b11: begin if (wen) begin mem[mad] = 16'hFFFF; busy = busy_len; end poll_pending = 1; end
              default: begin
                if (mad[5:0] != 0) frame_err++;
                case (mad[7:6])
                  2'b11: wen = 1;
                  2'b00: wen = 0;
                  2'b10: begin
                    if (wen) begin for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF; busy = busy_len; end
                    poll_pending = 1;
                  end
                  default: begin
                    if (wen) begin for (int i = 0; i < 256; i++) mem[i] = mdat; busy = busy_len; end
                    poll_pending = 1;
                  end
                endcase
              end
            endcase
          end
        end else poll_pending = 0;
        mdo = 1'b1; ph = 0; sk_per = 0; poll_ses = 0;
      end
      // selected behaviour
      if (mw_cs) begin
        if (poll_ses) begin
          if (mw_sk && !sk_p && mw_di) rel_cnt++;
          mdo = (busy == 0);
        end else if (mw_sk && !sk_p) begin
          nb++;
          case (ph)
            0: if (mw_di) begin ph = 1; n = 0; end
            1: begin
              mop = {mop[0], mw_di}; n++;
              if (n == 2) begin ph = 2; n = 0; end
            end
            2: begin
              mad = {mad[6:0], mw_di}; n++;
              if (n == 8) begin
                n = 0;
                if (mop == 2'b10) begin ph = 4; rword = mem[mad]; mdo = 1'b0; end
                else if (mop == 2'b01 || (mop == 2'b00 && mad[7:6] == 2'b01)) ph = 5;
                else ph = 3;
              end
            end
            5: begin
              mdat = {mdat[14:0], mw_di}; n++;
              if (n == 16) ph = 3;
            end
            4: begin
              mdo = (n < 16) ? rword[15 - n] : 1'b0; n++;
            end
            default: frame_err++;
          endcase
        end
      end
      cs_p = mw_cs; sk_p = mw_sk;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [15:0] got_rd;
  logic        got_to;

  task automatic do_cmd(input int c, input int a, input int d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = 3'(c); req_addr = 8'(a); req_wdata = 16'(d); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (!rsp_done) @(negedge clk);
    got_rd = rsp_rdata; got_to = rsp_timeout;
  endtask

  function automatic int pat(input int a);
    return ((a << 8) | a) ^ 16'h3C5A;
  endfunction

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r0, f0;
    rst_n = 1'b0; req_start = 1'b0; req_cmd = 0; req_addr = 0; req_wdata = 0;
    repeat (4) @(negedge clk);
    chk(!mw_cs && !mw_sk && !mw_di && req_ready && !rsp_done && !rsp_timeout, "R1 in reset",
        {mw_cs, mw_sk, mw_di, req_ready, rsp_done, rsp_timeout}, 6'b000100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mw_cs && !mw_sk && !mw_di && req_ready && !rsp_done, "R1 after reset",
        {mw_cs, mw_sk, mw_di, req_ready, rsp_done}, 5'b00010);

    // enable-modify: 11-edge frame, no busy wait
    r0 = rel_cnt;
    do_cmd(3, 0, 0);
    chk(last_nb == 11, "R4 enable frame length", last_nb, 11);
    chk(mop == 2'b00 && mad == 8'hC0 && wen, "R3 enable code", {mop, mad}, 10'h0C0);
    chk(rel_cnt == r0, "R6 no wait after enable", rel_cnt, r0);

    // store sweep over every word address
    for (int a = 0; a < 256; a++) begin
      r0 = rel_cnt;
      do_cmd(1, a, pat(a));
      chk(!got_to && rel_cnt == r0 + 1, "R6 store wait and release", rel_cnt, r0 + 1);
      chk(last_nb == 27 && mop == 2'b01 && mad == 8'(a) && mdat == 16'(pat(a)),
          "R2 store frame", {last_nb[7:0], mad, mdat}, {8'd27, 8'(a), 16'(pat(a))});
    end
    // read sweep
    for (int a = 0; a < 256; a++) begin
      do_cmd(0, a, 0);
      chk(got_rd == 16'(pat(a)), "R5 read data", got_rd, pat(a));
      if (a == 0) chk(last_nb == 28, "R5 read frame length", last_nb, 28);
    end

    // clear one cell
    do_cmd(2, 5, 0);
    chk(mop == 2'b11 && mad == 8'd5, "R3 clear code", {mop, mad}, 10'h305);
    do_cmd(0, 5, 0);
    chk(got_rd == 16'hFFFF, "R3 clear result", got_rd, 16'hFFFF);

    // disable then store: memory must refuse
    do_cmd(4, 0, 0);
    chk(mad == 8'h00 && !wen, "R3 disable code", mad, 0);
    do_cmd(1, 7, 16'h0000);
    do_cmd(0, 7, 0);
    chk(got_rd == 16'(pat(7)), "R3 store after disable ignored", got_rd, pat(7));

    // store-all and clear-all
    do_cmd(3, 0, 0);
    do_cmd(6, 0, 16'h1234);
    chk(mad == 8'h40 && last_nb == 27, "R3 store-all frame", {last_nb[7:0], mad}, 16'h1B40);
    do_cmd(0, 0, 0);   chk(got_rd == 16'h1234, "R3 store-all cell 0", got_rd, 16'h1234);
    do_cmd(0, 255, 0); chk(got_rd == 16'h1234, "R3 store-all cell 255", got_rd, 16'h1234);
    do_cmd(5, 0, 0);
    chk(mad == 8'h80 && last_nb == 11, "R3 clear-all frame", {last_nb[7:0], mad}, 16'h0B80);
    do_cmd(0, 200, 0); chk(got_rd == 16'hFFFF, "R3 clear-all cell 200", got_rd, 16'hFFFF);

    // busy wait that expires
    busy_len = 1000;
    r0 = rel_cnt;
    do_cmd(1, 9, 16'hAAAA);
    chk(got_to == 1'b1, "R7 timeout flagged", got_to, 1);
    chk(rel_cnt == r0, "R7 no release on timeout", rel_cnt, r0);
    repeat (1100) @(negedge clk);
    busy_len = 20;
    do_cmd(0, 9, 0);
    chk(got_to == 1'b0 && got_rd == 16'hAAAA, "R7 flag cleared", {got_to, got_rd}, 17'h0AAAA);

    // start while busy is ignored
    f0 = frames;
    @(negedge clk);
    req_cmd = 3'd0; req_addr = 8'd9; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(!req_ready, "R10 ready low while busy", req_ready, 0);
    req_cmd = 3'd1; req_addr = 8'd9; req_wdata = 16'h0000; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (!rsp_done) @(negedge clk);
    chk(req_ready, "R10 ready rises with done", req_ready, 1);
    chk(rsp_rdata == 16'hAAAA, "R10 read unaffected", rsp_rdata, 16'hAAAA);
    @(negedge clk);
    chk(!rsp_done, "R10 done is one cycle", rsp_done, 0);
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R10 single frame", frames, f0 + 1);

    chk(sk_err == 0, "R8 serial clock shape", sk_err, 0);
    chk(min_cslow >= 2*HALF, "R9 deselect gap", min_cslow, 2*HALF);
    chk(frame_err == 0, "R3 zero low address bits", frame_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule